// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

This block turns a stream of parallel words into a single serial line. Each word is wrapped in a 12-position frame whose first position is always 1 and whose last position is always 0. That fixed 1-to-0 pair gives the receiver a guaranteed transition in every frame, so it can recover the word timing from the line itself. The block runs on a fast clock gated by a bit enable and emits one serial position per enable pulse. It derives the word clock internally from its own position counter, so the serial rate is exactly twelve times the word rate and the payload rate is ten times the word rate.

Two request inputs let a downstream receiver ask for training frames. The two requests are combined with OR. Once a request has been held long enough, the block stops sending data and sends frames of six ones followed by six zeros. It always sends a minimum burst of them. An output-enable input and a power input control whether the line is driven; the undriven state is modelled by a low output-valid flag. After reset, and after every power-up, the line stays undriven for a fixed settling interval.

Top module: `serfr_tx`

## Requirements
- R1: Each frame is 12 serial positions, numbered 0 to 11. Position 0 carries 1, positions 1 to 10 carry payload bits 0 to 9 (least significant first), and position 11 carries 0.
- R2: The position counter advances by one per cycle with `bit_en` high. `word_clk` is high for positions 0 to 5 and low for positions 6 to 11. While `bit_en` is low, the position, `ser_out` and `word_clk` hold.
- R3: With `edge_sel` high, the frame starting at a rise of `word_clk` carries the value `din` had at that rise. With `edge_sel` low, it carries the value `din` had at the preceding fall of `word_clk`.
- R4: At a frame boundary where `sync_a` or `sync_b` is high and training is not active, the next frame has an all-zero payload, and `din` is ignored.
- R5: A request must be seen high at 5 consecutive frame boundaries. The frame loaded at the boundary after the fifth is a training frame: positions 0 to 5 carry 1 and positions 6 to 11 carry 0.
- R6: Once a request qualifies, at least 1024 training frames are sent, even if the request drops at once. When a request is released right after qualifying, exactly 1024 training frames are sent, followed by data.
- R7: Training continues for as long as a qualified request stays high. After both requests go low, exactly one more training frame is sent, provided the 1024 minimum is already spent.
- R8: After reset release, and after `pwr_on` returns high, `ser_oe` stays low for 510 words (6120 enabled bit cycles) and rises as the first frame after that begins.
- R9: With `out_en` low, `ser_oe` and `ser_out` are low. Frame timing and training progress continue unaffected, so raising `out_en` resumes the sequence where it would have been.
- R10: With `pwr_on` low, `ser_oe` is low and all internal state returns to its reset values.
- R11: While `rst_n` is low, `ser_oe` and `ser_out` are low and `word_clk` is high (position 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One serial position per cycle with this high |
| din | input | DATA_W | Parallel payload word |
| edge_sel | input | 1 | 1: take `din` at the rise of `word_clk`; 0: take it at the fall |
| sync_a | input | 1 | Training request, first source |
| sync_b | input | 1 | Training request, second source |
| out_en | input | 1 | Line drive enable |
| pwr_on | input | 1 | 0 powers the block down |
| ser_out | output | 1 | Serial line (0 while not valid) |
| ser_oe | output | 1 | Line valid; low models high impedance |
| word_clk | output | 1 | Derived word clock, high for the first half of each frame |

## Verification
The assertions take for granted that requests and `din` are quasi-static with respect to the internal frame positions. They assume requests are only meaningful when sampled at a frame boundary, and that `bit_en` may stall at any cycle without `pwr_on` changing in the same cycle. The stimulus follows these rules. It changes `din`, the requests and `edge_sel` only just after the `word_clk` rise, changes `din` again just after the fall, and changes `out_en` only in the last position of a frame. This gives every frame one unambiguous captured word and one enable value. The stall test is run only after the frame traffic has drained.

// File: rtl/serfr_pkg.sv
// Shared types and helpers for the embedded-clock frame serializer.
// Assumes frame widths below 64 positions.
package serfr_pkg;

    // Content class of the frame loaded at a boundary
    typedef enum logic [1:0] {
        FK_DATA  = 2'd0,
        FK_IDLE  = 2'd1,
        FK_TRAIN = 2'd2
    } frame_kind_t;

    // Vector with the n lowest bits set (training half-frame of ones)
    function automatic logic [63:0] low_ones(input int n);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < n) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/serfr_word_timer.sv
// Frame position counter. One position per bit_en pulse, wrapping at
// FRAME_W. Produces the boundary tick (last position being left), the
// mid-frame tick (first half being left) and the derived word clock.
// Assumes FRAME_W is even.
module serfr_word_timer #(
    parameter int FRAME_W = 12,
    parameter int SLOT_W  = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              bit_en,
    output logic [SLOT_W-1:0] slot,
    output logic              boundary,
    output logic              mid_tick,
    output logic              word_clk
);
    localparam int HALF = FRAME_W / 2;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);
    localparam logic [SLOT_W-1:0] MID_SLOT  = SLOT_W'(HALF - 1);

    logic [SLOT_W-1:0] slot_q;

    // Advance the frame position on each enabled bit cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on) begin
            slot_q <= '0;
        end else if (bit_en) begin
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        end
    end

    // Decode ticks and the word clock from the position
    always_comb begin
        slot     = slot_q;
        boundary = bit_en && (slot_q == LAST_SLOT);
        mid_tick = bit_en && (slot_q == MID_SLOT);
        word_clk = (slot_q < SLOT_W'(HALF));
    end

endmodule

// File: rtl/serfr_link_ctrl.sv
// Link sequencing: settling interval after reset or power-up, request
// qualification over consecutive boundaries, and the minimum training
// burst counter. Decides the kind of frame to load at each boundary.
// Assumes boundary pulses once per frame and sync_req is sampled only there.
module serfr_link_ctrl
    import serfr_pkg::*;
#(
    parameter int SETTLE_WORDS = 510,
    parameter int SYNC_HOLD    = 5,
    parameter int TRAIN_MIN    = 1024,
    parameter int SET_W        = $clog2(SETTLE_WORDS + 1),
    parameter int QUAL_W       = $clog2(SYNC_HOLD + 1),
    parameter int TRAIN_W      = $clog2(TRAIN_MIN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_on,
    input  logic               boundary,
    input  logic               sync_req,
    output logic               settled,
    output frame_kind_t        next_kind,
    output logic [SET_W-1:0]   settle_cnt,
    output logic [QUAL_W-1:0]  qual_cnt,
    output logic [TRAIN_W-1:0] train_left
);
    localparam logic [SET_W-1:0]   SETTLE_END = SET_W'(SETTLE_WORDS);
    localparam logic [QUAL_W-1:0]  QUAL_FULL  = QUAL_W'(SYNC_HOLD);
    localparam logic [QUAL_W-1:0]  QUAL_ARM   = QUAL_W'(SYNC_HOLD - 1);
    localparam logic [TRAIN_W-1:0] TRAIN_LOAD = TRAIN_W'(TRAIN_MIN);

    logic [SET_W-1:0]   settle_q;
    logic [QUAL_W-1:0]  qual_q;
    logic [TRAIN_W-1:0] train_q;
    logic               arm_now;
    logic               settled_w;

    assign settled_w = (settle_q == SETTLE_END);
    assign arm_now   = boundary && sync_req && (qual_q == QUAL_ARM);

    // Count words since reset or power-up until the settling interval ends
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on) begin
            settle_q <= '0;
        end else if (boundary && !settled_w) begin
            settle_q <= settle_q + 1'b1;
        end
    end

    // Count consecutive boundaries with a request present, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on || !settled_w) begin
            qual_q <= '0;
        end else if (boundary) begin
            if (!sync_req)              qual_q <= '0;
            else if (qual_q != QUAL_FULL) qual_q <= qual_q + 1'b1;
        end
    end

    // Re-arm the minimum burst on qualification, spend it per training frame
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on || !settled_w) begin
            train_q <= '0;
        end else if (arm_now) begin
            train_q <= TRAIN_LOAD;
        end else if (boundary && (train_q != '0)) begin
            train_q <= train_q - 1'b1;
        end
    end

    // Choose the content of the frame loaded at the coming boundary
    always_comb begin
        if (!settled_w)                               next_kind = FK_DATA;
        else if ((qual_q == QUAL_FULL) || (train_q != '0)) next_kind = FK_TRAIN;
        else if (sync_req)                            next_kind = FK_IDLE;
        else                                          next_kind = FK_DATA;
    end

    assign settled    = settled_w;
    assign settle_cnt = settle_q;
    assign qual_cnt   = qual_q;
    assign train_left = train_q;

endmodule

// File: rtl/serfr_frame_shift.sv
// Frame builder and shifter. Captures the payload on the selected word
// clock edge, loads a framed word, idle word or training pattern at each
// boundary and shifts it out least significant position first.
// Assumes din is stable around the capture points.
module serfr_frame_shift
    import serfr_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              bit_en,
    input  logic              boundary,
    input  logic              mid_tick,
    input  logic              edge_sel,
    input  logic [DATA_W-1:0] din,
    input  frame_kind_t       next_kind,
    output logic              ser_bit,
    output frame_kind_t       cur_kind
);
    localparam int HALF = FRAME_W / 2;
    localparam logic [FRAME_W-1:0] TRAIN_PAT = FRAME_W'(low_ones(HALF));

    logic [DATA_W-1:0]  hold_q;
    logic [DATA_W-1:0]  word;
    logic [FRAME_W-1:0] shreg_q;
    logic [FRAME_W-1:0] load_val;
    frame_kind_t        kind_q;

    // Falling-edge capture: take din as the word clock drops
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on) begin
            hold_q <= '0;
        end else if (mid_tick && !edge_sel) begin
            hold_q <= din;
        end
    end

    // Pick the payload source and build the frame to load
    always_comb begin
        word = edge_sel ? din : hold_q;
        unique case (next_kind)
            FK_TRAIN: load_val = TRAIN_PAT;
            FK_IDLE:  load_val = {1'b0, {DATA_W{1'b0}}, 1'b1};
            default:  load_val = {1'b0, word, 1'b1};
        endcase
    end

    // Load at the boundary, otherwise shift one position per bit cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on) begin
            shreg_q <= '0;
            kind_q  <= FK_DATA;
        end else if (bit_en) begin
            if (boundary) begin
                shreg_q <= load_val;
                kind_q  <= next_kind;
            end else begin
                shreg_q <= {1'b0, shreg_q[FRAME_W-1:1]};
            end
        end
    end

    assign ser_bit  = shreg_q[0];
    assign cur_kind = kind_q;

endmodule

// File: rtl/serfr_tx.sv
// Embedded-clock frame serializer top. Combines the requests, gates the
// line with the settle state, out_en and pwr_on, and connects the timer,
// the sequencer and the frame shifter.
// Assumes a single clock; bit_en sets the serial rate.
module serfr_tx
    import serfr_pkg::*;
#(
    parameter int DATA_W       = 10,
    parameter int SETTLE_WORDS = 510,
    parameter int SYNC_HOLD    = 5,
    parameter int TRAIN_MIN    = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] din,
    input  logic              edge_sel,
    input  logic              sync_a,
    input  logic              sync_b,
    input  logic              out_en,
    input  logic              pwr_on,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              word_clk
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int SLOT_W  = $clog2(FRAME_W);
    localparam int SET_W   = $clog2(SETTLE_WORDS + 1);
    localparam int QUAL_W  = $clog2(SYNC_HOLD + 1);
    localparam int TRAIN_W = $clog2(TRAIN_MIN + 1);

    logic [SLOT_W-1:0]  slot_w;
    logic               boundary_w;
    logic               mid_w;
    logic               sync_req;
    logic               settled_w;
    frame_kind_t        next_kind_w;
    frame_kind_t        cur_kind_w;
    logic [SET_W-1:0]   settle_cnt_w;
    logic [QUAL_W-1:0]  qual_cnt_w;
    logic [TRAIN_W-1:0] train_left_w;
    logic               ser_bit_w;

    assign sync_req = sync_a | sync_b;

    serfr_word_timer #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_on   (pwr_on),
        .bit_en   (bit_en),
        .slot     (slot_w),
        .boundary (boundary_w),
        .mid_tick (mid_w),
        .word_clk (word_clk)
    );

    serfr_link_ctrl #(
        .SETTLE_WORDS (SETTLE_WORDS),
        .SYNC_HOLD    (SYNC_HOLD),
        .TRAIN_MIN    (TRAIN_MIN),
        .SET_W        (SET_W),
        .QUAL_W       (QUAL_W),
        .TRAIN_W      (TRAIN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_on     (pwr_on),
        .boundary   (boundary_w),
        .sync_req   (sync_req),
        .settled    (settled_w),
        .next_kind  (next_kind_w),
        .settle_cnt (settle_cnt_w),
        .qual_cnt   (qual_cnt_w),
        .train_left (train_left_w)
    );

    serfr_frame_shift #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_on    (pwr_on),
        .bit_en    (bit_en),
        .boundary  (boundary_w),
        .mid_tick  (mid_w),
        .edge_sel  (edge_sel),
        .din       (din),
        .next_kind (next_kind_w),
        .ser_bit   (ser_bit_w),
        .cur_kind  (cur_kind_w)
    );

    // Drive the line only when settled, enabled and powered
    always_comb begin
        ser_oe  = settled_w && out_en && pwr_on;
        ser_out = ser_oe && ser_bit_w;
    end

endmodule

// File: rtl/serfr_tx_chk.sv
// Property checker for serfr_tx, attached with bind. Relates the frame
// position, the sequencer counters and the serial line.
// Assumes the parameters match the bound instance.
module serfr_tx_chk
    import serfr_pkg::*;
#(
    parameter int FRAME_W      = 12,
    parameter int SLOT_W       = 4,
    parameter int SETTLE_WORDS = 510,
    parameter int SYNC_HOLD    = 5,
    parameter int TRAIN_MIN    = 1024,
    parameter int SET_W        = 9,
    parameter int QUAL_W       = 3,
    parameter int TRAIN_W      = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwr_on,
    input logic               bit_en,
    input logic               sync_req,
    input logic               boundary,
    input logic [SLOT_W-1:0]  slot,
    input logic               ser_out,
    input logic               ser_oe,
    input frame_kind_t        cur_kind,
    input logic [SET_W-1:0]   settle_cnt,
    input logic [QUAL_W-1:0]  qual_cnt,
    input logic [TRAIN_W-1:0] train_left
);
    localparam int HALF = FRAME_W / 2;

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && slot == '0) |-> ser_out);

    // R1
    stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && slot == SLOT_W'(FRAME_W - 1)) |-> !ser_out);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && pwr_on) |=> $stable(slot));

    // R4
    idle_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && cur_kind == FK_IDLE && slot != '0) |-> !ser_out);

    // R5
    train_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && cur_kind == FK_TRAIN) |-> (ser_out == (slot < SLOT_W'(HALF))));

    // R6
    train_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && boundary && sync_req && qual_cnt == QUAL_W'(SYNC_HOLD - 1)
         && settle_cnt == SET_W'(SETTLE_WORDS))
        |=> (train_left == TRAIN_W'(TRAIN_MIN)));

    // R6
    train_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && boundary && train_left != '0
         && !(sync_req && qual_cnt == QUAL_W'(SYNC_HOLD - 1)))
        |=> (train_left == $past(train_left) - 1'b1));

    // R8
    settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe |-> (settle_cnt == SET_W'(SETTLE_WORDS)));

endmodule

bind serfr_tx serfr_tx_chk #(
    .FRAME_W      (FRAME_W),
    .SLOT_W       (SLOT_W),
    .SETTLE_WORDS (SETTLE_WORDS),
    .SYNC_HOLD    (SYNC_HOLD),
    .TRAIN_MIN    (TRAIN_MIN),
    .SET_W        (SET_W),
    .QUAL_W       (QUAL_W),
    .TRAIN_W      (TRAIN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_on     (pwr_on),
    .bit_en     (bit_en),
    .sync_req   (sync_req),
    .boundary   (boundary_w),
    .slot       (slot_w),
    .ser_out    (ser_out),
    .ser_oe     (ser_oe),
    .cur_kind   (cur_kind_w),
    .settle_cnt (settle_cnt_w),
    .qual_cnt   (qual_cnt_w),
    .train_left (train_left_w)
);

// File: tb/sim_serfr_tx.sv
// Scoreboard bench for serfr_tx: a driver task queues the expected frame
// for each frame it shapes, and a monitor rebuilds frames from the line.
module sim_serfr_tx;
    localparam logic [11:0] IDLE_F  = 12'h001;
    localparam logic [11:0] TRAIN_F = 12'h03F;

    typedef struct {
        int          idx;
        logic [11:0] bits;
        logic        oe;
        int          req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b1;
    logic [9:0] din = '0;
    logic       edge_sel = 1'b1;
    logic       sync_a = 1'b0;
    logic       sync_b = 1'b0;
    logic       out_en = 1'b1;
    logic       pwr_on = 1'b1;
    logic       ser_out;
    logic       ser_oe;
    logic       word_clk;

    int   n_chk = 0;
    int   n_bad = 0;
    int   frame_no = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    serfr_tx u0 (
        .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .din (din),
        .edge_sel (edge_sel), .sync_a (sync_a), .sync_b (sync_b),
        .out_en (out_en), .pwr_on (pwr_on), .ser_out (ser_out),
        .ser_oe (ser_oe), .word_clk (word_clk)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] dframe(input logic [9:0] v);
        return {1'b0, v, 1'b1};
    endfunction

    // Monitor: rebuild each frame from position 0 and compare with the queue
    logic        wc_prev = 1'b0;
    int          nbit = 12;
    logic [11:0] got;
    logic        oe_all;
    logic        oe_any;
    always @(negedge clk) begin
        if (word_clk && !wc_prev) begin
            frame_no++;
            nbit   = 0;
            oe_all = 1'b1;
            oe_any = 1'b0;
        end
        wc_prev = word_clk;
        if (nbit < 12) begin
            got[nbit] = ser_out;
            oe_all &= ser_oe;
            oe_any |= ser_oe;
            nbit++;
            if (nbit == 12 && q.size() > 0 && q[0].idx == frame_no) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (got !== e.bits || oe_all !== e.oe || oe_any !== e.oe) begin
                    n_bad++;
                    $display("FAIL R%0d frame %0d actual=%03h/oe%0b expected=%03h/oe%0b",
                             e.req, frame_no, got, oe_any, e.bits, e.oe);
                end
            end
        end
    end

    // Wait for the negedge that sees position 0 after a word clock rise
    task automatic wait_rise();
        logic p;
        p = word_clk;
        forever begin
            @(negedge clk);
            if (word_clk && !p) break;
            p = word_clk;
        end
    endtask

    // Driver: shape one frame's inputs and queue the next frame's expectation
    task automatic step(input logic [9:0] d, input logic [9:0] junk,
                        input logic sa, input logic sb, input logic en,
                        input logic es, input logic [11:0] xb, input int req);
        wait_rise();
        #2;
        din = d; sync_a = sa; sync_b = sb; edge_sel = es;
        repeat (6) @(negedge clk);
        #2 din = junk;
        repeat (5) @(negedge clk);
        #2 out_en = en;
        q.push_back('{frame_no + 1, en ? xb : 12'h000, en, req});
    endtask

    function automatic logic [9:0] pat(input int i);
        case (i)
            0: return 10'h3FF;
            1: return 10'h000;
            2: return 10'h155;
            3: return 10'h2AA;
            4: return 10'h201;
            default: return 10'h0F0;
        endcase
    endfunction

    // Count enabled bit cycles until the line becomes valid
    task automatic measure_settle(input string req);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ser_oe && n < 7000);
        check(n == 6120, req, "cycles to line valid", n, 6120);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        check(ser_oe == 1'b0, "R11", "ser_oe in reset", ser_oe, 0);
        check(ser_out == 1'b0, "R11", "ser_out in reset", ser_out, 0);
        check(word_clk == 1'b1, "R11", "word_clk in reset", word_clk, 1);
        #2 rst_n = 1'b1;
        // R8: settling interval after reset
        measure_settle("R8");

        // R1 R3: rising-edge capture takes din at the word clock rise
        for (int i = 0; i < 6; i++)
            step(pat(i), ~pat(i), 1'b0, 1'b0, 1'b1, 1'b1, dframe(~pat(i)), 3);
        // R1 R3: falling-edge capture takes din at the word clock fall
        for (int i = 0; i < 6; i++)
            step(pat(i), ~pat(i), 1'b0, 1'b0, 1'b1, 1'b0, dframe(pat(i)), 3);

        // R4 R5: request held for only 4 boundaries gives idle frames, no training
        for (int k = 0; k < 4; k++)
            step(10'h155, 10'h2AA, 1'b0, 1'b1, 1'b1, 1'b1, IDLE_F, 4);
        step(10'h0C3, 10'h33C, 1'b0, 1'b0, 1'b1, 1'b1, dframe(10'h33C), 5);

        // R5 R6 R9: qualify then release; exactly 1024 training frames,
        // with the line disabled for three of them
        for (int k = 0; k <= 1029; k++) begin
            logic [9:0]  d;
            logic        en;
            logic [11:0] xb;
            int          r;
            d  = 10'(k * 37);
            en = !(k >= 100 && k <= 102);
            if (k < 5)          begin xb = IDLE_F;    r = 4; end
            else if (k <= 1028) begin xb = TRAIN_F;   r = en ? 6 : 9; end
            else                begin xb = dframe(~d); r = 6; end
            step(d, ~d, (k < 5), 1'b0, en, 1'b1, xb, r);
        end

        // R7: request held long, training lasts until one frame after release
        for (int k = 0; k <= 1101; k++) begin
            logic [9:0]  d;
            logic [11:0] xb;
            int          r;
            d = 10'(k * 91 + 5);
            if (k < 5)          begin xb = IDLE_F;    r = 4; end
            else if (k <= 1100) begin xb = TRAIN_F;   r = 7; end
            else                begin xb = dframe(~d); r = 7; end
            step(d, ~d, 1'b0, (k <= 1099), 1'b1, 1'b1, xb, r);
        end

        repeat (30) @(negedge clk);
        check(q.size() == 0, "R1", "expected frames left unseen", q.size(), 0);

        // R2: bit_en low freezes the line and word clock
        begin
            logic so;
            logic wc;
            #2 bit_en = 1'b0;
            @(negedge clk);
            so = ser_out; wc = word_clk;
            repeat (5) @(negedge clk);
            check(ser_out == so, "R2", "ser_out during stall", ser_out, so);
            check(word_clk == wc, "R2", "word_clk during stall", word_clk, wc);
            #2 bit_en = 1'b1;
        end

        // R9: out_en low gates the line
        @(negedge clk);
        #2 out_en = 1'b0;
        @(negedge clk);
        check(ser_oe == 1'b0, "R9", "ser_oe with out_en low", ser_oe, 0);
        check(ser_out == 1'b0, "R9", "ser_out with out_en low", ser_out, 0);
        #2 out_en = 1'b1;

        // R10: powerdown drops the line at once and restarts settling
        @(negedge clk);
        #2 pwr_on = 1'b0;
        @(negedge clk);
        check(ser_oe == 1'b0, "R10", "ser_oe in powerdown", ser_oe, 0);
        repeat (3) @(negedge clk);
        check(word_clk == 1'b1, "R10", "word_clk reset in powerdown", word_clk, 1);
        #2 pwr_on = 1'b1;
        measure_settle("R10");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule